// File: doc/BRIEF.md
# Three-Level Page Walker with 64KiB Contiguous-Leaf Detection

This block turns a virtual page number into a TLB fill by reading page table entries from memory one level at a time. A request carries a 27-bit virtual page number and the physical page number of the root table. The walker then reads one 64-bit entry per level, starting at the top level (level 2) and moving down toward the 4KiB level (level 0). It follows pointer entries until it reaches a leaf. It then emits the entry, the level where it was found and the requested page number, all in one result cycle. If the walk breaks a rule, it emits a fault in that cycle instead.

The walker also recognises a 64KiB contiguous leaf. Such a leaf is a 4KiB-level entry with its top bit set and a physical-page low nibble of 4'b1000. It stands for 16 consecutive, naturally aligned 4KiB pages. The entry is passed on without change, and a separate flag marks it, so that the TLB can match it against all 16 pages. Any other use of the top bit is a fault.

The controller has four states. IDLE accepts a request. ISSUE holds a read on the memory port until it is taken. AWAIT waits for the response and decides what happens next. REPORT drives the one-cycle result. The transitions are:
- IDLE→ISSUE on an accepted request.
- ISSUE→AWAIT on the read handshake.
- AWAIT→ISSUE on a pointer entry, moving one level down.
- AWAIT→REPORT on a leaf or a fault.
- REPORT→IDLE unconditionally.

Top module: `napot_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready`=1 and `mem_req_valid`, `done`, `fault` and `upd_valid` are all 0.
- R2: The read for each level goes to address `table_ppn*4096 + vpn_slice*8`. The slice for level L is `vpn[9L+8:9L]`. The first read uses the root and level 2, and each pointer's PPN (bits 53:10) becomes the table for the level below.
- R3: An entry with V (bit 0)=1, R (bit 1)=0, W (bit 2)=0 and X (bit 3)=0 is a pointer, and the walk continues one level down. An entry with V=1 and R=1 or X=1 is a leaf. A leaf ends the walk with `upd_valid`, `upd_pte` equal to the entry and `upd_level` equal to the level where the leaf was read (2, 1 or 0).
- R4: An entry with V=0, or with W=1 and R=0, ends the walk with `fault`=1 and `upd_valid`=0.
- R5: A leaf at level 0 whose N bit (bit 63) is 1 and whose PPN bits 13:10 equal 4'b1000 is reported with `upd_napot`=1, and `upd_pte` equals the entry exactly as read.
- R6: `upd_napot` is 0 for every leaf that is not described by R5.
- R7: An entry with N=1 and PPN bits 13:10 other than 4'b1000 raises a fault.
- R8: An entry with N=1 raises a fault when it is a leaf at level 2 or 1, and when it is a pointer.
- R9: A pointer read at level 0 raises a fault.
- R10: Each walk ends with `done` high for exactly one cycle. In that cycle exactly one of `fault` and `upd_valid` is 1, and `upd_vpn` equals the requested VPN.
- R11: `req_ready` is 1 only in IDLE. A request presented while a walk is in progress is ignored.
- R12: At most one read is outstanding. While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vpn | input | 27 | Virtual page number to translate |
| req_root_ppn | input | 44 | Physical page number of the root table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory takes the read |
| mem_req_addr | output | 56 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 64 | Entry read from memory |
| done | output | 1 | One-cycle end-of-walk pulse |
| fault | output | 1 | Walk ended in a page fault |
| upd_valid | output | 1 | TLB fill present |
| upd_pte | output | 64 | Leaf entry, unmodified |
| upd_level | output | 2 | Level of the leaf (2, 1, 0) |
| upd_vpn | output | 27 | VPN of the finished walk |
| upd_napot | output | 1 | Leaf spans 16 contiguous 4KiB pages |

## Verification
The bench builds the block with its default widths: three levels, 9-bit indices, 44-bit PPNs and 64-bit entries. With these widths an inexpensive sweep can place the entry under test at each of the three levels. The sweep crosses that position with every N value, all 16 low PPN nibbles, all eight R/W/X patterns and both V values. This reaches every NAPOT-legal, reserved and misplaced encoding, including a pointer at the last level. Half of the walks stall the memory port so that the held-request rule is exercised. A directed run presents requests while a walk is busy.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int BIT_V     = 0;
    localparam int BIT_R     = 1;
    localparam int BIT_W     = 2;
    localparam int BIT_X     = 3;
    localparam int PPN_LSB   = 10;
    localparam int NAPOT_NIB = 4;
    localparam logic [NAPOT_NIB-1:0] NAPOT_64K = 4'b1000;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_AWAIT,
        ST_REPORT
    } walk_state_e;

    typedef struct packed {
        logic bad;
        logic leaf;
        logic contig;
    } pte_class_t;
endpackage

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode
    import ptw_pkg::*;
#(
    parameter int PTE_W = 64,
    parameter int LVL_W = 2
) (
    input  logic [PTE_W-1:0] pte,
    input  logic [LVL_W-1:0] level,
    output pte_class_t       cls
);
    logic v, r, w, x, n, leaf, nib_ok;

    always_comb begin
        v      = pte[BIT_V];
        r      = pte[BIT_R];
        w      = pte[BIT_W];
        x      = pte[BIT_X];
        n      = pte[PTE_W-1];
        leaf   = r | x;
        nib_ok = (pte[PPN_LSB +: NAPOT_NIB] == NAPOT_64K);

        cls.leaf   = leaf;
        cls.contig = n && leaf && nib_ok && (level == '0);
        cls.bad    = !v
                   || (w && !r)
                   || (!leaf && level == '0)
                   || (n && !cls.contig);
    end
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int LEVELS = 3,
    parameter int IDX_W  = 9,
    parameter int PPN_W  = 44,
    parameter int OFS_W  = 12,
    parameter int PTE_W  = 64,
    localparam int VPN_W   = LEVELS * IDX_W,
    localparam int LVL_W   = $clog2(LEVELS),
    localparam int PA_W    = PPN_W + OFS_W,
    localparam int ENTRY_B = $clog2(PTE_W / 8)
) (
    input  logic [PPN_W-1:0] table_ppn,
    input  logic [VPN_W-1:0] vpn,
    input  logic [LVL_W-1:0] level,
    output logic [PA_W-1:0]  addr
);
    logic [IDX_W-1:0] slice;

    always_comb begin
        slice = vpn[level * IDX_W +: IDX_W];
        addr  = (PA_W'(table_ppn) << OFS_W) + (PA_W'(slice) << ENTRY_B);
    end
endmodule

// File: rtl/napot_walker.sv
module napot_walker
    import ptw_pkg::*;
#(
    parameter int LEVELS = 3,
    parameter int IDX_W  = 9,
    parameter int PPN_W  = 44,
    parameter int OFS_W  = 12,
    parameter int PTE_W  = 64,
    localparam int VPN_W = LEVELS * IDX_W,
    localparam int LVL_W = $clog2(LEVELS),
    localparam int PA_W  = PPN_W + OFS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VPN_W-1:0] req_vpn,
    input  logic [PPN_W-1:0] req_root_ppn,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    output logic             done,
    output logic             fault,
    output logic             upd_valid,
    output logic [PTE_W-1:0] upd_pte,
    output logic [LVL_W-1:0] upd_level,
    output logic [VPN_W-1:0] upd_vpn,
    output logic             upd_napot
);
    localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);

    walk_state_e      state_q, state_d;
    logic [VPN_W-1:0] vpn_q;
    logic [PPN_W-1:0] base_q;
    logic [LVL_W-1:0] lvl_q;
    logic [PTE_W-1:0] pte_q;
    logic             bad_q;
    logic             contig_q;
    pte_class_t       cls;
    logic [PA_W-1:0]  rd_addr;

    ptw_pte_decode #(.PTE_W(PTE_W), .LVL_W(LVL_W)) u_decode (
        .pte   (mem_rsp_data),
        .level (lvl_q),
        .cls   (cls)
    );

    ptw_addr_gen #(
        .LEVELS(LEVELS), .IDX_W(IDX_W), .PPN_W(PPN_W),
        .OFS_W(OFS_W), .PTE_W(PTE_W)
    ) u_addr (
        .table_ppn (base_q),
        .vpn       (vpn_q),
        .level     (lvl_q),
        .addr      (rd_addr)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_ISSUE;
            ST_ISSUE:  if (mem_req_ready) state_d = ST_AWAIT;
            ST_AWAIT:  if (mem_rsp_valid) begin
                           if (cls.bad || cls.leaf) state_d = ST_REPORT;
                           else                     state_d = ST_ISSUE;
                       end
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and walk context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            vpn_q    <= '0;
            base_q   <= '0;
            lvl_q    <= '0;
            pte_q    <= '0;
            bad_q    <= 1'b0;
            contig_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) begin
                vpn_q    <= req_vpn;
                base_q   <= req_root_ppn;
                lvl_q    <= TOP_LVL;
                bad_q    <= 1'b0;
                contig_q <= 1'b0;
            end
            if (state_q == ST_AWAIT && mem_rsp_valid) begin
                pte_q <= mem_rsp_data;
                if (cls.bad) begin
                    bad_q <= 1'b1;
                end else if (cls.leaf) begin
                    contig_q <= cls.contig;
                end else begin
                    base_q <= mem_rsp_data[PPN_LSB +: PPN_W];
                    lvl_q  <= lvl_q - 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        mem_req_valid = (state_q == ST_ISSUE);
        mem_req_addr  = rd_addr;
        done          = (state_q == ST_REPORT);
        fault         = done && bad_q;
        upd_valid     = done && !bad_q;
        upd_napot     = upd_valid && contig_q;
        upd_pte       = pte_q;
        upd_level     = lvl_q;
        upd_vpn       = vpn_q;
    end
endmodule

// File: rtl/napot_walker_chk.sv
module napot_walker_chk #(
    parameter int PTE_W = 64,
    parameter int PA_W  = 56,
    parameter int LVL_W = 2,
    parameter int PPN_LSB = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [PA_W-1:0]  mem_req_addr,
    input logic             mem_rsp_valid,
    input logic             done,
    input logic             fault,
    input logic             upd_valid,
    input logic [PTE_W-1:0] upd_pte,
    input logic [LVL_W-1:0] upd_level,
    input logic             upd_napot
);
    logic pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              pend_q <= 1'b0;
        else if (mem_req_valid && mem_req_ready) pend_q <= 1'b1;
        else if (mem_rsp_valid)                  pend_q <= 1'b0;
    end

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R12
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !pend_q);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $countones({fault, upd_valid}) == 1);

    // R11
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid || pend_q |-> !req_ready);

    // R5
    napot_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_napot |-> upd_valid && upd_level == '0 && upd_pte[PTE_W-1]
                      && upd_pte[PPN_LSB +: 4] == 4'b1000);

    // R4
    leaf_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> upd_pte[0] && (upd_pte[1] || upd_pte[3])
                      && !(upd_pte[2] && !upd_pte[1]));
endmodule

bind napot_walker napot_walker_chk #(
    .PTE_W(PTE_W), .PA_W(PA_W), .LVL_W(LVL_W), .PPN_LSB(10)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .done          (done),
    .fault         (fault),
    .upd_valid     (upd_valid),
    .upd_pte       (upd_pte),
    .upd_level     (upd_level),
    .upd_napot     (upd_napot)
);

// File: tb/napot_walker_tb.sv
module napot_walker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [26:0] req_vpn = '0;
    logic [43:0] req_root_ppn = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [55:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        done, fault, upd_valid, upd_napot;
    logic [63:0] upd_pte;
    logic [1:0]  upd_level;
    logic [26:0] upd_vpn;

    int checks = 0;
    int failures = 0;
    bit stall_mode = 1'b0;
    logic [63:0] mem [logic [55:0]];
    logic [55:0] seen_addr [$];

    always #10 clk = ~clk;

    napot_walker u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vpn(req_vpn), .req_root_ppn(req_root_ppn),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .fault(fault), .upd_valid(upd_valid),
        .upd_pte(upd_pte), .upd_level(upd_level),
        .upd_vpn(upd_vpn), .upd_napot(upd_napot)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] rd(input logic [55:0] a);
        return mem.exists(a) ? mem[a] : 64'd0;
    endfunction

    // memory model: one-cycle response, optional alternating stall
    initial begin
        bit          pend = 1'b0;
        logic [55:0] pa = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = pend;
            mem_rsp_data  = pend ? rd(pa) : 64'd0;
            pend = 1'b0;
            mem_req_ready = stall_mode ? ~mem_req_ready : 1'b1;
            if (mem_req_valid && mem_req_ready) begin
                pend = 1'b1;
                pa   = mem_req_addr;
                seen_addr.push_back(mem_req_addr);
            end
        end
    end

    // reference walk from the requirements (R2..R9)
    task automatic ref_walk(input logic [26:0] vpn, input logic [43:0] root,
                            output bit flt, output logic [63:0] pte,
                            output logic [1:0] lvl, output bit nap,
                            output int naddr, output logic [55:0] a0);
        logic [43:0] base = root;
        flt = 0; nap = 0; pte = '0; lvl = 2; naddr = 0; a0 = '0;
        for (int L = 2; L >= 0; L--) begin
            logic [55:0] a = ({12'd0, base} << 12) + (56'(vpn[L*9 +: 9]) << 3);
            logic [63:0] p = rd(a);
            bit isleaf = p[1] | p[3];
            if (naddr == 0) a0 = a;
            naddr++;
            pte = p; lvl = 2'(L);
            if (!p[0] || (p[2] && !p[1])) begin flt = 1; return; end
            if (isleaf) begin
                if (p[63]) begin
                    if (L != 0 || p[13:10] != 4'b1000) flt = 1;
                    else nap = 1;
                end
                return;
            end
            if (p[63] || L == 0) begin flt = 1; return; end
            base = p[53:10];
        end
    endtask

    task automatic walk(input logic [26:0] vpn, input logic [43:0] root,
                        input bit poke, input string tag);
        bit eflt, enap; logic [63:0] epte; logic [1:0] elvl;
        int en, wait_n; logic [55:0] ea0;
        ref_walk(vpn, root, eflt, epte, elvl, enap, en, ea0);
        seen_addr.delete();
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_vpn = vpn; req_root_ppn = root;
        @(negedge clk);
        if (poke) req_vpn = ~vpn; else req_valid = 1'b0;
        wait_n = 0;
        while (!done && wait_n < 60) begin
            if (poke) chk(!req_ready, "R11", "ready while busy", 64'(req_ready), 0);
            @(negedge clk); wait_n++;
        end
        req_valid = 1'b0;
        chk(done, "R10", {tag, " done seen"}, 64'(done), 1);
        if (done) begin
            chk(fault == eflt && upd_valid == !eflt, tag, "fault/update",
                {62'd0, fault, upd_valid}, {62'd0, eflt, !eflt});
            chk(upd_vpn == vpn, "R10", "upd_vpn", 64'(upd_vpn), 64'(vpn));
            chk(upd_napot == enap, "R6", "napot flag", 64'(upd_napot), 64'(enap));
            if (!eflt) begin
                chk(upd_pte == epte, "R3", "leaf pte", upd_pte, epte);
                chk(upd_level == elvl, "R3", "leaf level", 64'(upd_level), 64'(elvl));
            end
            chk(seen_addr.size() == en && seen_addr[0] == ea0, "R2", "reads",
                64'(seen_addr.size()), 64'(en));
        end
        @(negedge clk);
        chk(!done, "R10", "done one cycle", 64'(done), 0);
    endtask

    initial begin
        int k = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready && !mem_req_valid && !done && !fault && !upd_valid,
            "R1", "reset outputs",
            {59'd0, req_ready, mem_req_valid, done, fault, upd_valid}, 64'h10);
        rst_n = 1'b1;
        @(negedge clk);

        for (int lvl = 0; lvl < 3; lvl++)
        for (int n = 0; n < 2; n++)
        for (int lo = 0; lo < 16; lo++)
        for (int rwx = 0; rwx < 8; rwx++)
        for (int v = 0; v < 2; v++) begin
            logic [26:0] vpn;
            logic [43:0] root, b1, b0;
            logic [63:0] tpe;
            string tag;
            vpn  = {9'(k * 7 + 3), 9'(k * 13 + 5), 9'(k * 29 + 1)};
            root = 44'h1000 + 44'(k);
            b1   = 44'h20000 + 44'(k * 3);
            b0   = 44'h40000 + 44'(k * 5);
            tpe  = {1'(n), 9'd0, 40'(k * 1234 + 7), 4'(lo), 6'b010101, 3'(rwx), 1'(v)};
            mem.delete();
            if (lvl == 2) mem[({12'd0, root} << 12) + (56'(vpn[26:18]) << 3)] = tpe;
            else begin
                mem[({12'd0, root} << 12) + (56'(vpn[26:18]) << 3)] = {10'd0, b1, 10'h001};
                if (lvl == 1) mem[({12'd0, b1} << 12) + (56'(vpn[17:9]) << 3)] = tpe;
                else begin
                    mem[({12'd0, b1} << 12) + (56'(vpn[17:9]) << 3)] = {10'd0, b0, 10'h001};
                    mem[({12'd0, b0} << 12) + (56'(vpn[8:0]) << 3)] = tpe;
                end
            end
            if (v == 0 || (rwx[1] && !rwx[0])) tag = "R4";
            else if (n == 1 && rwx != 0 && lvl != 0) tag = "R8";
            else if (n == 1 && rwx != 0 && lo != 8) tag = "R7";
            else if (n == 1 && rwx != 0) tag = "R5";
            else if (n == 1) tag = "R8";
            else if (rwx == 0 && lvl == 0) tag = "R9";
            else tag = "R3";
            stall_mode = k[0];
            walk(vpn, root, 1'b0, tag);
            k++;
        end

        // R11: request held high during a walk is ignored
        mem.delete();
        mem[(56'h5000 << 12) + (56'd9 << 3)] = {1'b1, 9'd0, 40'hABCDE, 4'b1000, 6'd0, 3'b011, 1'b1};
        walk({9'd9, 9'd0, 9'd0}, 44'h5000, 1'b1, "R11");
        mem[(56'h5000 << 12) + (56'd9 << 3)] = {1'b0, 9'd0, 40'h12, 4'b0011, 6'd0, 3'b001, 1'b1};
        stall_mode = 1'b1;
        walk({9'd9, 9'd4, 9'd2}, 44'h5000, 1'b1, "R12");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule